// File: doc/BRIEF.md
# Wait-State External Bus Controller

This block is the processor side of a parallel external bus. It runs read and write cycles to memory-mapped peripherals such as parallel converters and latches. A cycle starts in one of two ways: the core pulses a request, or a peripheral raises an interrupt line, for example on conversion complete or when it is ready for the next sample. The cycle uses the operation, address space, address and write data that the core presents. The controller first drives the address and an active-low select for the chosen space. One quarter processor period later it pulls the read or write strobe low. The strobe stays low for half a processor period plus one full period for each wait state programmed for that space.

Each of the four address spaces (boot, program, data, I/O) has its own 4-bit wait-state field. The block runs on a clock four times the processor clock, so one tick is a quarter period. The strobe is therefore low for 2 + 4·W ticks. Read data is sampled in the tick where the read strobe rises. Write data is driven onto the bus, with its output enable, while the write strobe is low and for one tick after it rises. A single comparator in the block decodes a peripheral chip select. When the cycle finishes, the controller gives the core a one-tick completion pulse.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `rd_n`, `wr_n`, `cs_n` and every bit of `sel_n` are high, and `busy`, `done` and `bus_oe` are low.
- R2: A started cycle drives `bus_addr`, and the single low `sel_n` bit whose index is the space code (0 boot, 1 program, 2 data, 3 I/O), for exactly one tick before the strobe falls.
- R3: The strobe (`rd_n` when `op_wr`=0, `wr_n` when `op_wr`=1) stays low for exactly 2 + 4·W ticks. W is `ws_cfg[4*s+3:4*s]` for the addressed space s. The fields of the other spaces have no effect.
- R4: On a read, `rdata` equals the value `bus_din` had in the last tick the read strobe was low. It is valid when `done` is high.
- R5: On a write, `bus_oe` is high and `bus_dout` carries the write data while `wr_n` is low and for exactly one tick after `wr_n` rises. At all other times `bus_oe` is low.
- R6: Address and select stay unchanged for the whole cycle, including one hold tick after the strobe rises. The select is then released, and `done` pulses high for one tick with `busy` low.
- R7: A rising edge on `irq` while idle starts a cycle, exactly as `req` does. Holding `irq` high does not start another cycle.
- R8: A `req` that arrives while `busy` is high is ignored. The cycle in progress keeps its address and select, and no further cycle follows.
- R9: `cs_n` is low during a cycle only when the space is data (code 2) and `op_addr[15:8]` equals 8'h40. Otherwise it is high.
- R10: The read and write strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, four ticks per processor period |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Core request to start a cycle |
| irq | input | 1 | Peripheral interrupt; its rising edge starts a cycle |
| op_wr | input | 1 | 1 for a write, 0 for a read |
| op_space | input | 2 | Address space code |
| op_addr | input | 16 | Cycle address |
| op_wdata | input | 16 | Write data |
| ws_cfg | input | 16 | Four 4-bit wait-state fields, space s at bits 4s+3..4s |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-tick completion pulse |
| rdata | output | 16 | Captured read data |
| bus_addr | output | 16 | External address |
| sel_n | output | 4 | Active-low space selects |
| cs_n | output | 1 | Decoded peripheral chip select |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| bus_dout | output | 16 | Write data toward the bus |
| bus_oe | output | 1 | Output enable for the data bus driver |
| bus_din | input | 16 | Read data from the bus |

## Verification
The hardest cases to reach from the ports involve overlap: a request that lands while a long cycle is in progress, and an interrupt line that stays high across the completion tick. The bench reaches the first by pulsing `req` in the middle of a strobe stretched by three wait states, with a different address. It then watches the bus through the end of the cycle and for several idle ticks. The bench reaches the second by holding `irq` high well beyond the cycle it started. To pin down the read capture tick, the bench changes `bus_din` in every tick, so a capture one tick early or late returns the wrong word.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int NSP = 4,
  parameter int WSW = 4,
  parameter int CS_SPACE = 2,
  parameter logic [AW-1:0] CS_BASE = 16'h4000,
  parameter logic [AW-1:0] CS_MASK = 16'hFF00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 irq,
  input  logic                 op_wr,
  input  logic [$clog2(NSP)-1:0] op_space,
  input  logic [AW-1:0]        op_addr,
  input  logic [DW-1:0]        op_wdata,
  input  logic [NSP*WSW-1:0]   ws_cfg,
  output logic                 busy,
  output logic                 done,
  output logic [DW-1:0]        rdata,
  output logic [AW-1:0]        bus_addr,
  output logic [NSP-1:0]       sel_n,
  output logic                 cs_n,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic [DW-1:0]        bus_dout,
  output logic                 bus_oe,
  input  logic [DW-1:0]        bus_din
);
  localparam int SPW = $clog2(NSP);
  localparam int CW  = WSW + 2;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           irq_q, wr_q;
  logic [SPW-1:0] sp_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wd_q;
  logic [WSW-1:0] ws_sel;
  logic           go;

  assign go     = (st == S_IDLE) && (req || (irq && !irq_q));
  assign ws_sel = ws_cfg[sp_q*WSW +: WSW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      irq_q  <= 1'b0;
      wr_q   <= 1'b0;
      sp_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      irq_q <= irq;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st     <= S_SETUP;
          wr_q   <= op_wr;
          sp_q   <= op_space;
          addr_q <= op_addr;
          wd_q   <= op_wdata;
        end
        S_SETUP: begin
          st  <= S_STROBE;
          cnt <= {ws_sel, 2'b01};
        end
        S_STROBE: begin
          if (cnt == '0) begin
            st <= S_HOLD;
            if (!wr_q) rdata <= bus_din;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign bus_addr = addr_q;
  assign bus_dout = wd_q;
  assign rd_n     = !((st == S_STROBE) && !wr_q);
  assign wr_n     = !((st == S_STROBE) && wr_q);
  assign bus_oe   = wr_q && ((st == S_STROBE) || (st == S_HOLD));
  assign cs_n     = !(busy && (sp_q == SPW'(CS_SPACE)) && ((addr_q & CS_MASK) == CS_BASE));

  always_comb begin
    sel_n = '1;
    if (busy) sel_n[sp_q] = 1'b0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && !bus_oe && (sel_n == '1)));

  assert_select_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> ($past(sel_n) == sel_n) && (sel_n != '1));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |=> $stable(bus_addr) && $stable(sel_n));

  assert_oe_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!wr_n || $rose(wr_n)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_cs_in_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> $onehot(~sel_n));
endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, irq = 1'b0, op_wr = 1'b0;
  logic [1:0] op_space = '0;
  logic [15:0] op_addr = '0, op_wdata = '0, bus_din = '0;
  logic [15:0] ws_cfg = '0;
  logic busy, done, cs_n, rd_n, wr_n, bus_oe;
  logic [15:0] rdata, bus_addr, bus_dout;
  logic [3:0] sel_n;
  int checks = 0, errors = 0;
  logic [15:0] din_ctr = 16'h1000;

  always #5 clk = ~clk;

  xbus_ctrl i_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .irq(irq), .op_wr(op_wr),
    .op_space(op_space), .op_addr(op_addr), .op_wdata(op_wdata), .ws_cfg(ws_cfg),
    .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr), .sel_n(sel_n),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din));

  always @(posedge clk) begin
    #2;
    din_ctr = din_ctr + 16'h0101;
    bus_din = din_ctr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // vector: [31:28] wr, [27:24] space, [23:20] ws, [19:16] addr hi nibble, [15:8] addr low, [7:0] data
  localparam logic [31:0] VEC [8] = '{
    32'h0000_1200, 32'h1204_34A5, 32'h0214_5600, 32'h1131_783C,
    32'h03F4_9A00, 32'h1370_BC5A, 32'h0225_DE00, 32'h10F4_F0C3 };

  // Called at the negedge where the controller is in its setup tick.
  task automatic watch(input bit wr, input int sp, input logic [15:0] addr,
                       input logic [15:0] wd, input int ws, input bit cs_exp);
    int setup = 0, low = 0, hold = 0, n = 0;
    logic [15:0] last_din = '0;
    bit seen_done = 0, sel_ok = 1, addr_ok = 1, cs_ok = 1, oe_ok = 1;
    while (n < 200) begin
      if (done) begin seen_done = 1; break; end
      if (busy) begin
        if (sel_n != ~(4'b1 << sp)) sel_ok = 0;
        if (bus_addr != addr) addr_ok = 0;
        if (cs_n != !cs_exp) cs_ok = 0;
      end
      if (!rd_n || !wr_n) begin
        low++;
        last_din = bus_din;
        if (wr && !(bus_oe && bus_dout == wd)) oe_ok = 0;
        if (!wr && bus_oe) oe_ok = 0;
      end else if (busy && low == 0) begin
        setup++;
        if (bus_oe) oe_ok = 0;
      end else if (busy) begin
        hold++;
        if (wr && !(bus_oe && bus_dout == wd)) oe_ok = 0;
        if (!wr && bus_oe) oe_ok = 0;
      end
      n++;
      @(negedge clk);
    end
    chk(seen_done, "R6 done pulse seen", seen_done, 1);
    chk(setup == 1, "R2 setup ticks", setup, 1);
    chk(low == 2 + 4*ws, "R3 strobe low ticks", low, 2 + 4*ws);
    chk(hold == 1, "R6 hold ticks", hold, 1);
    chk(sel_ok && addr_ok, "R6 select/address held", {sel_ok, addr_ok}, 3);
    chk(cs_ok, "R9 chip select", cs_ok, 1);
    chk(oe_ok, "R5 output enable window", oe_ok, 1);
    chk(sel_n == 4'hF && !busy && !bus_oe, "R6 released at done", sel_n, 4'hF);
    if (!wr) chk(rdata == last_din, "R4 read capture", rdata, last_din);
  endtask

  task automatic cfg_ws(input int sp, input int ws);
    for (int s = 0; s < 4; s++) ws_cfg[4*s +: 4] = (s == sp) ? 4'(ws) : 4'(15 - ws);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && cs_n && sel_n == 4'hF && !busy && !done && !bus_oe,
        "R1 reset state", {rd_n, wr_n, cs_n, sel_n}, 7'h7F);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] v = VEC[i];
      op_wr    = v[28];
      op_space = v[25:24];
      op_addr  = {v[19:16], 4'h0, v[15:8]};
      op_wdata = {v[7:0], ~v[7:0]};
      cfg_ws(int'(v[25:24]), int'(v[23:20]));
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      watch(v[28], int'(v[25:24]), op_addr, op_wdata, int'(v[23:20]),
            v[25:24] == 2'd2 && v[19:16] == 4'h4);
      @(negedge clk);
    end

    // R7: interrupt-started write, irq held high afterwards
    op_wr = 1'b1; op_space = 2'd2; op_addr = 16'h4077; op_wdata = 16'hBEEF;
    cfg_ws(2, 1);
    irq = 1'b1;
    @(negedge clk);
    watch(1'b1, 2, 16'h4077, 16'hBEEF, 1, 1'b1);
    begin
      bit retrig = 0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); if (busy) retrig = 1; end
      chk(!retrig, "R7 held irq no retrigger", retrig, 0);
    end
    irq = 1'b0;
    @(negedge clk);

    // R8: request while busy is ignored
    op_wr = 1'b0; op_space = 2'd1; op_addr = 16'h1234;
    cfg_ws(1, 3);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    op_space = 2'd3; op_addr = 16'h5555; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(bus_addr == 16'h1234 && sel_n == 4'b1101, "R8 busy request ignored", bus_addr, 16'h1234);
    begin
      int guard = 0;
      while (!done && guard < 100) begin @(negedge clk); guard++; end
      chk(done, "R8 first cycle completes", done, 1);
    end
    begin
      bit extra = 0;
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (busy) extra = 1; end
      chk(!extra, "R8 no cycle after ignored request", extra, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule